// File: doc/BRIEF.md
# Dual-Bank Configurable Multiply-Accumulate Array

This block is a 21-tap multiply-accumulate engine built from three rows of seven transposed filter stages. Each row takes its own 8-bit sample on every clock. Each row's sample goes to all seven of its stages at once. A stage adds its product to the registered result of the stage before it. The end of each row passes through one extra register before it enters the first stage of the next row. In window mode the three rows carry three independent inputs and form a 3x7 two-dimensional window. In chained mode, rows one and two take the row-zero stream delayed inside the block. The three rows then act as a single 21-tap linear filter.

Two coefficient banks hold 21 coefficients each. One bank serves the arithmetic while the other can be rewritten, and the stream does not pause. The bank is chosen per output result. A select pipeline runs alongside the stages, so every product that forms one output uses the same bank. In manual mode the bank follows a select pin. In alternating mode the bank flips on every clock, and the select pin decides which bank comes first. The data and the coefficients are each read as two's complement or as unsigned, set by their own pins. The sum leaves the block at full precision.

Top module: `mac_array_dual_bank`

## Requirements
- R1: While `rst` is high at a clock edge, every stage, the link registers, the bank pipeline and both banks clear, and `y` reads 0.
- R2: With `mode_1d` low, a row-r sample present at edge n is multiplied by the coefficient at address 7r+k (k = 0..6) and contributes to `y` after edge n + 8(2-r) + 7 - k. `y` is the signed sum of all such contributions.
- R3: With `mode_1d` high, the row-1 and row-2 bytes of `row_data` have no effect. Row r uses the row-0 sample delayed by r edges, so a row-0 sample present at edge n meets address a in `y` after edge n + 23 - a.
- R4: `data_signed` high reads a sample byte as two's complement (-128..127). Low reads it as unsigned (0..255). The choice is made when the sample is captured.
- R5: `coef_signed` high reads coefficients as two's complement. Low reads them as unsigned. The choice applies to each product as it is formed.
- R6: Sums are exact in a 23-bit signed `y`. All-255 unsigned data and coefficients give 1365525. Data 0x80 signed against coefficient 0xFF unsigned gives -685440.
- R7: Every product of the `y` value that appears after edge E uses one bank: the bank selected at edge E-23. In manual mode the bank selected at an edge is the `bank_sel` value at that edge (0 = bank 0, 1 = bank 1).
- R8: When `auto_swap` was high at the previous edge, the bank selected flips at every edge. On the first edge after it rises, the bank selected is `bank_sel`.
- R9: A write (`cw_en`) stores `cw_data` at address `cw_addr` of bank `cw_bank`. The address is 7*row + tap. The write is ignored if the address is 21 or more. It is also ignored if that bank was selected at any of the 23 edges before the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| row_data | input | 24 | Row samples, row r in bits [8r+7:8r] |
| mode_1d | input | 1 | 1 = chained 21-tap line, 0 = 3x7 window |
| data_signed | input | 1 | 1 = samples are two's complement |
| coef_signed | input | 1 | 1 = coefficients are two's complement |
| bank_sel | input | 1 | Manual bank choice, or first bank when alternating |
| auto_swap | input | 1 | 1 = alternate banks on every clock |
| cw_en | input | 1 | Coefficient write strobe |
| cw_bank | input | 1 | Bank targeted by the write |
| cw_addr | input | 5 | Coefficient address, 7*row + tap |
| cw_data | input | 8 | Coefficient value |
| y | output | 23 | Full-precision signed sum |

## Verification
A stale or mis-aimed coefficient, a wrong sign extension or a broken link register changes `y`. The error shows up no later than 23 edges after the sample or product that touched it. A bank select that reaches some stages too early gives outputs that match neither bank around every swap. This fault appears in the first output after the switch that crosses the pipeline. A write that slips into a bank still in flight corrupts only the outputs of that bank. The stimulus therefore returns to the guarded bank after each rejected write.

// File: rtl/mac_arr_pkg.sv
package mac_arr_pkg;

  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned DEF_COEF_W = 8;
  localparam int unsigned DEF_TAPS   = 7;
  localparam int unsigned DEF_ROWS   = 3;

  // Registers between a stage's product and the output register.
  function automatic int unsigned stage_dist(int unsigned r, int unsigned k,
                                             int unsigned taps, int unsigned rows);
    return (rows - 1 - r) * (taps + 1) + (taps - 1 - k);
  endfunction

endpackage

// File: rtl/mac_bank_seq.sv
module mac_bank_seq #(
  parameter int unsigned DEPTH = 23
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bank_sel,
  input  logic             auto_swap,
  input  logic             probe_bank,
  output logic [DEPTH-1:0] pipe,
  output logic             probe_busy
);

  logic auto_run;

  // pipe[j] is the bank selected j edges ago; pipe[0] is the newest choice.
  always_ff @(posedge clk) begin
    if (rst) begin
      pipe     <= '0;
      auto_run <= 1'b0;
    end else begin
      auto_run <= auto_swap;
      pipe     <= {pipe[DEPTH-2:0], auto_run ? ~pipe[0] : bank_sel};
    end
  end

  // A bank is busy while any in-flight output still refers to it.
  assign probe_busy = probe_bank ? (|pipe) : ~(&pipe);

  // R8
  auto_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    auto_run |=> (pipe[0] != $past(pipe[0])));

  // R9
  auto_locks_banks_chk: assert property (@(posedge clk) disable iff (rst)
    (auto_run && $past(auto_run)) |-> (pipe[0] != pipe[1]));

endmodule

// File: rtl/mac_coef_store.sv
module mac_coef_store #(
  parameter int unsigned COEF_W = 8,
  parameter int unsigned TOTAL  = 21,
  parameter int unsigned ADDR_W = 5
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic                         wr_bank,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [COEF_W-1:0]            wr_data,
  input  logic                         wr_blocked,
  output logic [TOTAL-1:0][COEF_W-1:0] bank0,
  output logic [TOTAL-1:0][COEF_W-1:0] bank1
);

  logic wr_ok;
  assign wr_ok = wr_en && !wr_blocked && (wr_addr < ADDR_W'(TOTAL));

  always_ff @(posedge clk) begin
    if (rst) begin
      bank0 <= '0;
      bank1 <= '0;
    end else if (wr_ok) begin
      if (wr_bank) bank1[wr_addr] <= wr_data;
      else         bank0[wr_addr] <= wr_data;
    end
  end

  // R9
  oob_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_addr >= ADDR_W'(TOTAL))) |=> ($stable(bank0) && $stable(bank1)));

  // R9
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_blocked) |=> ($stable(bank0) && $stable(bank1)));

endmodule

// File: rtl/mac_row.sv
module mac_row #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned COEF_W = 8,
  parameter int unsigned TAPS   = 7,
  parameter int unsigned ACC_W  = 23
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic signed [DATA_W:0]      x_in,
  input  logic [TAPS-1:0][COEF_W-1:0] coef0,
  input  logic [TAPS-1:0][COEF_W-1:0] coef1,
  input  logic [TAPS-1:0]             sel,
  input  logic                        coef_signed,
  input  logic signed [ACC_W-1:0]     chain_in,
  output logic signed [ACC_W-1:0]     chain_out
);

  localparam int unsigned PROD_W = DATA_W + COEF_W + 2;

  for (genvar k = 0; k < TAPS; k++) begin : g_stage
    logic [COEF_W-1:0]        raw;
    logic signed [COEF_W:0]   ce;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  upstream;
    logic signed [ACC_W-1:0]  acc;

    assign raw  = sel[k] ? coef1[k] : coef0[k];
    assign ce   = $signed({coef_signed & raw[COEF_W-1], raw});
    assign prod = x_in * ce;

    if (k == 0) begin : g_head
      assign upstream = chain_in;
    end else begin : g_body
      assign upstream = g_stage[k-1].acc;
    end

    always_ff @(posedge clk) begin
      if (rst) acc <= '0;
      else     acc <= upstream + ACC_W'(prod);
    end
  end

  assign chain_out = g_stage[TAPS-1].acc;

endmodule

// File: rtl/mac_array_dual_bank.sv
module mac_array_dual_bank
  import mac_arr_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned COEF_W = DEF_COEF_W,
  parameter int unsigned TAPS   = DEF_TAPS,
  parameter int unsigned ROWS   = DEF_ROWS,
  localparam int unsigned TOTAL  = ROWS * TAPS,
  localparam int unsigned ADDR_W = $clog2(TOTAL + 1),
  localparam int unsigned ACC_W  = DATA_W + COEF_W + 2 + $clog2(TOTAL),
  localparam int unsigned SPAN   = stage_dist(0, 0, TAPS, ROWS) + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ROWS*DATA_W-1:0]   row_data,
  input  logic                     mode_1d,
  input  logic                     data_signed,
  input  logic                     coef_signed,
  input  logic                     bank_sel,
  input  logic                     auto_swap,
  input  logic                     cw_en,
  input  logic                     cw_bank,
  input  logic [ADDR_W-1:0]        cw_addr,
  input  logic [COEF_W-1:0]        cw_data,
  output logic signed [ACC_W-1:0]  y
);

  logic signed [DATA_W:0]      xq [ROWS];
  logic [SPAN-1:0]             bank_pipe;
  logic                        wr_busy;
  logic [TOTAL-1:0][COEF_W-1:0] bank0, bank1;

  // Input capture: extension by data_signed, row chaining in 1-D mode.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < ROWS; r++) xq[r] <= '0;
    end else begin
      xq[0] <= $signed({data_signed & row_data[DATA_W-1], row_data[DATA_W-1:0]});
      for (int r = 1; r < ROWS; r++) begin
        xq[r] <= mode_1d ? xq[r-1]
               : $signed({data_signed & row_data[r*DATA_W + DATA_W-1],
                          row_data[r*DATA_W +: DATA_W]});
      end
    end
  end

  mac_bank_seq #(.DEPTH(SPAN)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .bank_sel   (bank_sel),
    .auto_swap  (auto_swap),
    .probe_bank (cw_bank),
    .pipe       (bank_pipe),
    .probe_busy (wr_busy)
  );

  mac_coef_store #(.COEF_W(COEF_W), .TOTAL(TOTAL), .ADDR_W(ADDR_W)) u_store (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (cw_en),
    .wr_bank    (cw_bank),
    .wr_addr    (cw_addr),
    .wr_data    (cw_data),
    .wr_blocked (wr_busy),
    .bank0      (bank0),
    .bank1      (bank1)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic signed [ACC_W-1:0] cin;
    logic signed [ACC_W-1:0] cout;
    logic [TAPS-1:0]         sel;

    // Each stage reads the bank chosen for the output its product will reach.
    for (genvar k = 0; k < TAPS; k++) begin : g_sel
      assign sel[k] = bank_pipe[SPAN - 1 - stage_dist(r, k, TAPS, ROWS)];
    end

    if (r == 0) begin : g_first
      assign cin = '0;
    end else begin : g_link
      always_ff @(posedge clk) begin
        if (rst) cin <= '0;
        else     cin <= g_row[r-1].cout;
      end
    end

    mac_row #(.DATA_W(DATA_W), .COEF_W(COEF_W), .TAPS(TAPS), .ACC_W(ACC_W)) u_row (
      .clk         (clk),
      .rst         (rst),
      .x_in        (xq[r]),
      .coef0       (bank0[r*TAPS +: TAPS]),
      .coef1       (bank1[r*TAPS +: TAPS]),
      .sel         (sel),
      .coef_signed (coef_signed),
      .chain_in    (cin),
      .chain_out   (cout)
    );
  end

  assign y = g_row[ROWS-1].cout;

  for (genvar r = 1; r < ROWS; r++) begin : g_chain_chk
    // R3
    one_d_shift_chk: assert property (@(posedge clk) disable iff (rst)
      mode_1d |=> (xq[r] == $past(xq[r-1])));
  end

endmodule

// File: tb/mac_array_dual_bank_tb.sv
module mac_array_dual_bank_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TOTAL      = 21;
  localparam int SPAN       = 23;
  localparam int MAXE       = 1024;
  localparam int NSTIM      = 24;

  localparam logic [23:0] STIM [NSTIM] = '{
    24'h03_80_01, 24'h7F_11_FF, 24'h00_00_02, 24'h85_40_7F,
    24'hC3_21_80, 24'h10_F0_05, 24'hFF_FF_FF, 24'h02_09_C1,
    24'h44_6A_33, 24'h91_0E_F8, 24'h00_7F_00, 24'h5A_A5_3C,
    24'hE0_12_9D, 24'h01_01_01, 24'h80_80_80, 24'h37_C8_0B,
    24'h66_00_E4, 24'h0F_F1_70, 24'hA8_2B_46, 24'h19_D7_8F,
    24'h00_00_00, 24'hB4_5E_21, 24'h72_E9_FE, 24'h2C_03_97
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [23:0] row_data = '0;
  logic mode_1d = 1'b0, data_signed = 1'b0, coef_signed = 1'b0;
  logic bank_sel = 1'b0, auto_swap = 1'b0;
  logic cw_en = 1'b0, cw_bank = 1'b0;
  logic [4:0] cw_addr = '0;
  logic [7:0] cw_data = '0;
  logic signed [22:0] y;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_array_dual_bank u_dut (
    .clk(clk), .rst(rst), .row_data(row_data), .mode_1d(mode_1d),
    .data_signed(data_signed), .coef_signed(coef_signed), .bank_sel(bank_sel),
    .auto_swap(auto_swap), .cw_en(cw_en), .cw_bank(cw_bank), .cw_addr(cw_addr),
    .cw_data(cw_data), .y(y)
  );

  int checks = 0, fails = 0, edge_n = 0, arun = 0;
  int xqh [3][MAXE];
  int csh [MAXE];
  int bqh [MAXE];
  int mem [2][TOTAL];
  string tag = "R1";

  function automatic int dext(logic [7:0] v, logic s);
    return s ? int'($signed(v)) : int'(v);
  endfunction

  function automatic int bank_at(int t);
    return (t <= 0) ? 0 : bqh[t];
  endfunction

  // Direct convolution from the requirements: output after edge e.
  function automatic int model_y(int e);
    int b = bank_at(e - SPAN);
    int acc = 0;
    for (int r = 0; r < 3; r++) begin
      for (int k = 0; k < 7; k++) begin
        int m = e - ((2 - r) * 8 + 6 - k);
        if (m >= 1) acc += xqh[r][m-1] * dext(8'(mem[b][r*7+k]), logic'(csh[m][0]));
      end
    end
    return acc;
  endfunction

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d (edge %0d)", req, got, exp, edge_n);
    end
  endtask

  task automatic step();
    int n;
    if (rst) begin
      @(posedge clk); @(negedge clk);
      edge_n = 0; arun = 0;
      for (int b = 0; b < 2; b++) for (int a = 0; a < TOTAL; a++) mem[b][a] = 0;
      check("R1", int'(y), 0);
    end else begin
      n = edge_n + 1;
      xqh[0][n] = dext(row_data[7:0], data_signed);
      for (int r = 1; r < 3; r++)
        xqh[r][n] = mode_1d ? xqh[r-1][n-1] : dext(row_data[r*8 +: 8], data_signed);
      csh[n] = int'(coef_signed);
      if (cw_en && cw_addr < 5'(TOTAL)) begin
        bit busy = 1'b0;
        for (int j = 0; j < SPAN; j++) if (bank_at(n - 1 - j) == int'(cw_bank)) busy = 1'b1;
        if (!busy) mem[cw_bank][cw_addr] = int'(cw_data);
      end
      bqh[n] = (arun != 0) ? 1 - bank_at(n - 1) : int'(bank_sel);
      arun = int'(auto_swap);
      @(posedge clk); @(negedge clk);
      edge_n = n;
      check(tag, int'(y), model_y(n));
    end
  endtask

  task automatic steps(int count);
    for (int i = 0; i < count; i++) step();
  endtask

  task automatic load_bank(logic b, int mul, int add);
    cw_en = 1'b1; cw_bank = b;
    for (int a = 0; a < TOTAL; a++) begin
      cw_addr = 5'(a); cw_data = 8'((a * mul + add) & 255);
      step();
    end
    cw_en = 1'b0;
  endtask

  task automatic run_table();
    for (int i = 0; i < NSTIM; i++) begin
      row_data = STIM[i];
      if (tag == "R7" && i == 8)  bank_sel = 1'b0;
      if (tag == "R7" && i == 16) bank_sel = 1'b1;
      if (tag == "R8" && i == 5) begin
        cw_en = 1'b1; cw_bank = 1'b0; cw_addr = 5'd0; cw_data = 8'h11;
      end else begin
        cw_en = 1'b0;
      end
      step();
    end
    cw_en = 1'b0;
    row_data = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    tag = "R1";
    steps(3);
    rst = 1'b0;

    // R9: load bank 1 (idle after reset), switch, load bank 0, then rejected writes
    tag = "R9";
    bank_sel = 1'b0;
    load_bank(1'b1, 37, 5);
    bank_sel = 1'b1;
    steps(25);
    load_bank(1'b0, 53, 200);
    cw_en = 1'b1; cw_bank = 1'b1; cw_addr = 5'd3; cw_data = 8'h00; step();
    cw_bank = 1'b0; cw_addr = 5'd25; cw_data = 8'h55; step();
    cw_en = 1'b0;

    // R2: window mode, signed data and coefficients, bank 1
    tag = "R2"; data_signed = 1'b1; coef_signed = 1'b1;
    run_table(); steps(23);

    // R4: unsigned data
    tag = "R4"; data_signed = 1'b0;
    run_table(); steps(23);

    // R5: unsigned coefficients with signed data
    tag = "R5"; data_signed = 1'b1; coef_signed = 1'b0;
    run_table(); steps(23);

    // R3: chained mode, rows 1 and 2 carry junk
    tag = "R3"; coef_signed = 1'b1; mode_1d = 1'b1;
    run_table(); steps(23);
    mode_1d = 1'b0;

    // R7: manual swaps mid-stream
    tag = "R7";
    run_table(); steps(25);

    // R8: alternating banks, first bank from bank_sel, write attempt ignored
    tag = "R8"; bank_sel = 1'b1; auto_swap = 1'b1;
    run_table(); steps(3);
    auto_swap = 1'b0;
    steps(25);

    // R6: full precision extremes with bank 0 all 0xFF
    tag = "R6"; bank_sel = 1'b1;
    steps(25);
    load_bank(1'b0, 0, 255);
    bank_sel = 1'b0; row_data = 24'hFF_FF_FF; data_signed = 1'b0; coef_signed = 1'b0;
    steps(26);
    check("R6", int'(y), 1365525);
    coef_signed = 1'b1;
    steps(26);
    check("R6", int'(y), -5355);
    row_data = 24'h80_80_80; data_signed = 1'b1; coef_signed = 1'b0;
    steps(26);
    check("R6", int'(y), -685440);

    // R1: reset mid-stream clears the output
    tag = "R1"; rst = 1'b1;
    step();
    check("R1", int'(y), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule